// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a stereo serial audio stream into parallel samples. It is a slave on the link. The bit clock is the block's own clock, and the word clock and serial data are sampled on its rising edge. Each half of a word-clock period carries one channel. The block extracts one sample per half and aligns it into a 24-bit two's complement word. Once both channels of a frame are in, it presents the left/right pair with a single-cycle strobe.

Five layouts are handled by one datapath:
- MSB-justified with the word starting at the word-clock transition.
- A delayed variant whose word starts one bit later and whose left channel sits on the low word-clock level.
- Three right-aligned layouts of 16, 20 and 24 bits. In these the sample ends on the last bit of each half, whatever the half length.

The layout is taken from a 3-bit select while the receiver waits for its first word-clock transition after reset. It is then held until the next reset.

Top module: `ser_audio_rx`

## Requirements
- R1: Data is MSB first in two's complement and sampled on the rising edge of `clk`. The select codes are: 3'b000 right-aligned 16-bit, 3'b001 right-aligned 20-bit, 3'b010 MSB-justified 24-bit, 3'b011 delayed-by-one 24-bit (I2S), 3'b100 right-aligned 24-bit.
- R2: In code 010 the left channel is the half where `wclk_i` is high. Its sample is the first 24 bits of the half, beginning with the bit sampled on the first edge that sees the new word-clock level.
- R3: In code 011 the left channel is the half where `wclk_i` is low. The sample MSB is the bit one edge after the word-clock change. With 24-bit halves, the LSB is taken from the first bit sampled after the next word-clock change.
- R4: In codes 000, 001 and 100 (width N = 16, 20, 24), the sample is the last N bits before the next word-clock change. It is sign-extended from bit N-1 to 24 bits, for any half length of at least N.
- R5: In codes 010 and 011, a half carrying K < 24 bits yields those K bits in the top positions of the output, with zeros below.
- R6: `valid_o` is high for exactly one cycle per frame, once the right half has ended. In codes other than 011 it is seen after the second rising edge that samples the new-frame word-clock level; in code 011 it is seen after the third.
- R7: Halves received before the first word-clock transition after reset are discarded. A right half with no completed left half since the last pair produces no strobe.
- R8: `left_o` and `right_o` change only in the cycle in which `valid_o` is high.
- R9: The select is followed only until the first word-clock transition after reset. Later changes of `fmt_sel_i` have no effect until the next reset.
- R10: The codes 101, 110 and 111 behave as code 010. The internal format state resets to code 010.
- R11: While `rst_n` is low, `left_o` and `right_o` are zero and `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; everything is registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk_i | input | 1 | Word clock selecting the channel of each half-frame |
| sdata_i | input | 1 | Serial audio data, MSB first |
| fmt_sel_i | input | 3 | Layout select, sampled until the first word-clock transition |
| left_o | output | 24 | Left sample of the last complete frame |
| right_o | output | 24 | Right sample of the last complete frame |
| valid_o | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
The bench records the stream index of the first bit of every new left half. From it, the bench derives the rising edge at which the strobe becomes visible: two edges later for the justified layouts, and three edges later for the delayed layout, because of the extra word-clock register. At every falling edge it compares a free-running edge counter with that due edge, so a strobe that is early, late or missing is reported against R6. The data check is made on the same falling edge as the strobe. Between strobes, the bench records any change of the sample outputs and checks that none occurred.

// File: rtl/ser_audio_pkg.sv
package ser_audio_pkg;

    typedef enum logic [2:0] {
        FMT_LSB16 = 3'b000,
        FMT_LSB20 = 3'b001,
        FMT_MSB24 = 3'b010,
        FMT_I2S24 = 3'b011,
        FMT_LSB24 = 3'b100
    } fmt_e;

    localparam int NUM_RALIGN = 3;

    // Unused codes fall back to the MSB-justified layout.
    function automatic fmt_e decode_fmt(input logic [2:0] code);
        case (code)
            3'b000:  return FMT_LSB16;
            3'b001:  return FMT_LSB20;
            3'b011:  return FMT_I2S24;
            3'b100:  return FMT_LSB24;
            default: return FMT_MSB24;
        endcase
    endfunction

    function automatic logic is_ralign(input fmt_e f);
        return (f == FMT_LSB16) || (f == FMT_LSB20) || (f == FMT_LSB24);
    endfunction

endpackage

// File: rtl/ser_audio_front.sv
// Registers the serial inputs and builds a uniform "view": one data bit,
// the channel it belongs to, and a marker for the first bit of a half.
// For the delayed layout the word clock is delayed by one extra bit so
// that the rest of the datapath sees an MSB-justified stream.
module ser_audio_front #(
    parameter int WARM_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk_i,
    input  logic sdata_i,
    input  logic i2s_i,
    output logic bit_o,
    output logic left_o,
    output logic edge_o
);

    typedef struct packed {
        logic              sd;
        logic              lr;
        logic              lr_dly;
        logic              prev_left;
        logic [WARM_N-1:0] warm;
    } front_t;

    front_t f_d, f_q;
    logic   view_left;

    always_comb begin
        view_left = i2s_i ? ~f_q.lr_dly : f_q.lr;
        f_d           = f_q;
        f_d.sd        = sdata_i;
        f_d.lr        = wclk_i;
        f_d.lr_dly    = f_q.lr;
        f_d.prev_left = view_left;
        f_d.warm      = {f_q.warm[WARM_N-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign bit_o  = f_q.sd;
    assign left_o = view_left;
    // Edges are suppressed until the delay line holds real samples.
    assign edge_o = f_q.warm[WARM_N-1] && (view_left != f_q.prev_left);

endmodule

// File: rtl/ser_audio_word.sv
// Collects the bits of one half-frame and produces the aligned sample
// of the half that is ending whenever edge_i marks the start of a new one.
module ser_audio_word
    import ser_audio_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int NARROW_W = 16,
    parameter int MID_W    = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_i,
    input  logic                edge_i,
    input  fmt_e                fmt_i,
    output logic [SAMPLE_W-1:0] word_o
);

    localparam int CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);

    typedef struct packed {
        logic [SAMPLE_W-1:0] acc;
        logic [CNT_W-1:0]    cnt;
    } word_t;

    word_t w_d, w_q;

    logic [NUM_RALIGN-1:0][SAMPLE_W-1:0] ralign_word;
    logic [SAMPLE_W-1:0]                 ljust_word;

    // Right-aligned candidates: keep the low W bits, sign-extended.
    for (genvar g = 0; g < NUM_RALIGN; g++) begin : g_ralign
        localparam int W  = (g == 0) ? NARROW_W : (g == 1) ? MID_W : SAMPLE_W;
        localparam int SH = SAMPLE_W - W;
        logic signed [SAMPLE_W-1:0] up;
        assign up             = $signed(w_q.acc << SH);
        assign ralign_word[g] = up >>> SH;
    end

    // Left-justified: a short half is moved to the top, zeros below.
    always_comb begin
        if (w_q.cnt >= FULL) ljust_word = w_q.acc;
        else                 ljust_word = w_q.acc << (FULL - w_q.cnt);
    end

    always_comb begin
        case (fmt_i)
            FMT_LSB16: word_o = ralign_word[0];
            FMT_LSB20: word_o = ralign_word[1];
            FMT_LSB24: word_o = ralign_word[2];
            default:   word_o = ljust_word;
        endcase
    end

    always_comb begin
        w_d = w_q;
        if (edge_i) begin
            w_d.acc = {{(SAMPLE_W-1){1'b0}}, bit_i};
            w_d.cnt = CNT_W'(1);
        end else begin
            if (is_ralign(fmt_i) || (w_q.cnt < FULL)) begin
                w_d.acc = {w_q.acc[SAMPLE_W-2:0], bit_i};
            end
            if (w_q.cnt < FULL) begin
                w_d.cnt = w_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

endmodule

// File: rtl/ser_audio_pair.sv
// Pairs a finished left sample with the following right sample and
// publishes them together with a one-cycle strobe.
module ser_audio_pair #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fin_i,
    input  logic                ended_left_i,
    input  logic [SAMPLE_W-1:0] word_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic                locked_o
);

    typedef struct packed {
        logic                locked;
        logic                have_left;
        logic [SAMPLE_W-1:0] hold;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                valid;
    } pair_t;

    pair_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.valid = 1'b0;
        if (fin_i) begin
            p_d.locked = 1'b1;
            // The half ending at the first transition began mid-way: drop it.
            if (p_q.locked) begin
                if (ended_left_i) begin
                    p_d.hold      = word_i;
                    p_d.have_left = 1'b1;
                end else begin
                    if (p_q.have_left) begin
                        p_d.left  = p_q.hold;
                        p_d.right = word_i;
                        p_d.valid = 1'b1;
                    end
                    p_d.have_left = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign left_o   = p_q.left;
    assign right_o  = p_q.right;
    assign valid_o  = p_q.valid;
    assign locked_o = p_q.locked;

endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
    import ser_audio_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int NARROW_W = 16,
    parameter int MID_W    = 20,
    parameter int WARM_N   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wclk_i,
    input  logic                sdata_i,
    input  logic [2:0]          fmt_sel_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    typedef struct packed {
        fmt_e fmt;
    } ctl_t;

    ctl_t                ctl_d, ctl_q;
    fmt_e                fmt_cur;
    logic                locked;
    logic                fin;
    logic                view_left;
    logic                ended_left;
    logic                bit_v;
    logic [SAMPLE_W-1:0] word;

    assign fmt_cur = ctl_q.fmt;

    // Format follows the select only until the stream is locked.
    always_comb begin
        ctl_d = ctl_q;
        if (!locked) ctl_d.fmt = decode_fmt(fmt_sel_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{fmt: FMT_MSB24};
        else        ctl_q <= ctl_d;
    end

    ser_audio_front #(
        .WARM_N (WARM_N)
    ) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .wclk_i  (wclk_i),
        .sdata_i (sdata_i),
        .i2s_i   (fmt_cur == FMT_I2S24),
        .bit_o   (bit_v),
        .left_o  (view_left),
        .edge_o  (fin)
    );

    assign ended_left = ~view_left;

    ser_audio_word #(
        .SAMPLE_W (SAMPLE_W),
        .NARROW_W (NARROW_W),
        .MID_W    (MID_W)
    ) u_word (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_i  (bit_v),
        .edge_i (fin),
        .fmt_i  (fmt_cur),
        .word_o (word)
    );

    ser_audio_pair #(
        .SAMPLE_W (SAMPLE_W)
    ) u_pair (
        .clk          (clk),
        .rst_n        (rst_n),
        .fin_i        (fin),
        .ended_left_i (ended_left),
        .word_i       (word),
        .left_o       (left_o),
        .right_o      (right_o),
        .valid_o      (valid_o),
        .locked_o     (locked)
    );

endmodule

// File: rtl/ser_audio_rx_chk.sv
module ser_audio_rx_chk #(
    parameter int SAMPLE_W = 24,
    parameter int NARROW_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                valid_o,
    input logic [2:0]          fmt_q,
    input logic                locked,
    input logic                fin,
    input logic                ended_left,
    input logic [SAMPLE_W-1:0] word
);

    localparam int EXT_N = SAMPLE_W - NARROW_W + 1;

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_strobe_after_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(fin && !ended_left));

    assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(left_o) && $stable(right_o)) |-> valid_o);

    assert_narrow_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && fmt_q == 3'b000) |->
            (($countones(word[SAMPLE_W-1:NARROW_W-1]) == 0) ||
             ($countones(word[SAMPLE_W-1:NARROW_W-1]) == EXT_N)));

    assert_fmt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(fmt_q));

    assert_fmt_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_q <= 3'd4);

endmodule

bind ser_audio_rx ser_audio_rx_chk #(
    .SAMPLE_W (SAMPLE_W),
    .NARROW_W (NARROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .left_o     (left_o),
    .right_o    (right_o),
    .valid_o    (valid_o),
    .fmt_q      (fmt_cur),
    .locked     (locked),
    .fin        (fin),
    .ended_left (ended_left),
    .word       (word)
);

// File: tb/sim_ser_audio_rx.sv
`timescale 1ns/1ps
module sim_ser_audio_rx;

    localparam int MAXB = 2048;
    localparam int MAXF = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wclk = 1'b0;
    logic        sdata = 1'b0;
    logic [2:0]  fmt_sel = 3'b010;
    logic [23:0] left, right;
    logic        valid;

    ser_audio_rx u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wclk_i    (wclk),
        .sdata_i   (sdata),
        .fmt_sel_i (fmt_sel),
        .left_o    (left),
        .right_o   (right),
        .valid_o   (valid)
    );

    always #5 clk = ~clk;

    int ecnt = 0;
    always @(posedge clk) ecnt <= ecnt + 1;

    int checks = 0;
    int fails  = 0;

    logic        sbit [MAXB];
    logic        slr  [MAXB];
    int          slen;
    logic [23:0] exp_l [MAXF];
    logic [23:0] exp_r [MAXF];
    int          due   [MAXF];
    int          nexp, nseen, base;
    logic        active = 1'b0;
    logic        hold_bad;
    logic [23:0] last_l, last_r;
    string       cur_tag;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: samples on the falling edge, away from the register updates.
    always @(negedge clk) begin
        if (active) begin
            if (valid) begin
                if (nseen >= nexp) begin
                    chk(1'b0, "R7", "unexpected strobe", nseen, nexp);
                end else begin
                    chk(left  == exp_l[nseen], cur_tag, "left",  left,  exp_l[nseen]);
                    chk(right == exp_r[nseen], cur_tag, "right", right, exp_r[nseen]);
                    chk(ecnt == base + due[nseen], "R6", "strobe edge",
                        ecnt - base, due[nseen]);
                end
                nseen++;
                last_l = left;
                last_r = right;
            end else if (left != last_l || right != last_r) begin
                hold_bad = 1'b1;
            end
        end
    end

    function automatic int eff_code(input logic [2:0] c);
        return (c <= 3'd4) ? int'(c) : 2;
    endfunction

    function automatic int ralign_w(input int c);
        return (c == 0) ? 16 : (c == 1) ? 20 : 24;
    endfunction

    // Builds one stream: right-level lead-in, frames, trailing left half.
    task automatic build(input logic [2:0] code, input int nfr,
                         input int hmin, input int hmax);
        int   ec   = eff_code(code);
        logic llvl = (ec == 3) ? 1'b0 : 1'b1;
        int   off  = (ec == 3) ? 1 : 0;
        int   p    = 0;
        for (int i = 0; i < MAXB; i++) sbit[i] = 1'($urandom_range(0, 1));
        for (int i = 0; i < 8; i++) begin slr[p] = ~llvl; p++; end
        nexp = nfr;
        for (int f = 0; f < nfr; f++) begin
            for (int ch = 0; ch < 2; ch++) begin
                int          h = $urandom_range(hmin, hmax);
                logic [23:0] w = 24'($urandom);
                logic [23:0] e;
                for (int i = 0; i < h; i++) slr[p + i] = (ch == 0) ? llvl : ~llvl;
                if (ec == 2 || ec == 3) begin
                    int k = (h < 24) ? h : 24;
                    for (int j = 0; j < k; j++) sbit[p + off + j] = w[23 - j];
                    e = w & (24'hFFFFFF << (24 - k));
                end else begin
                    int n = ralign_w(ec);
                    for (int j = 0; j < n; j++) sbit[p + h - n + j] = w[n - 1 - j];
                    for (int j = 0; j < 24; j++) e[j] = (j < n) ? w[j] : w[n - 1];
                end
                if (ch == 0) exp_l[f] = e; else exp_r[f] = e;
                p += h;
            end
            due[f] = p + ((ec == 3) ? 3 : 2);
        end
        for (int i = 0; i < 12; i++) begin slr[p] = llvl; p++; end
        slen = p;
    endtask

    task automatic run(input logic [2:0] code, input int nfr, input int hmin,
                       input int hmax, input string tag, input int swap_at);
        build(code, nfr, hmin, hmax);
        cur_tag = tag;
        @(negedge clk);
        rst_n   = 1'b0;
        fmt_sel = code;
        wclk    = slr[0];
        sdata   = 1'b0;
        repeat (3) @(negedge clk);
        chk(left == 24'd0,  "R11", "left in reset",  left,  0);
        chk(right == 24'd0, "R11", "right in reset", right, 0);
        chk(valid == 1'b0,  "R11", "strobe in reset", valid, 0);
        nseen    = 0;
        hold_bad = 1'b0;
        last_l   = 24'd0;
        last_r   = 24'd0;
        rst_n    = 1'b1;
        base     = ecnt;
        active   = 1'b1;
        for (int k = 0; k < slen; k++) begin
            if (k > 0) @(negedge clk);
            wclk  = slr[k];
            sdata = sbit[k];
            if (k == swap_at) fmt_sel = ~code;
        end
        repeat (4) @(negedge clk);
        chk(nseen == nexp, "R7", "strobe count", nseen, nexp);
        chk(!hold_bad, "R8", "outputs moved between strobes", hold_bad, 0);
        active = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Directed layouts
        run(3'b010, 6, 24, 32, "R2", -1);
        run(3'b011, 6, 25, 32, "R3", -1);
        run(3'b011, 4, 24, 24, "R3", -1);   // LSB spills into next half
        run(3'b000, 6, 16, 32, "R4", -1);
        run(3'b000, 3, 16, 16, "R4", -1);   // exactly N bits per half
        run(3'b001, 6, 20, 32, "R4", -1);
        run(3'b100, 6, 24, 32, "R1", -1);
        run(3'b010, 5, 10, 23, "R5", -1);   // short MSB halves
        run(3'b011, 5, 12, 23, "R5", -1);
        run(3'b110, 4, 24, 30, "R10", -1);  // reserved code
        run(3'b111, 3, 24, 26, "R10", -1);
        run(3'b000, 6, 16, 28, "R9", 100);  // select flipped mid-stream
        run(3'b011, 6, 24, 28, "R9", 60);
        // Random mix
        for (int i = 0; i < 12; i++) begin
            logic [2:0] c  = 3'($urandom_range(0, 7));
            int         ec = eff_code(c);
            int         lo = (ec == 2 || ec == 3) ? 24 : ralign_w(ec);
            run(c, 8, lo, 32, "R1", -1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R6 actual=%0d expected=%0d", ecnt, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule